// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 256-byte non-volatile style memory on a two-wire bus. It has one clock line and one open-drain data line. Both lines are oversampled by a fast system clock. The block recognises bus start and stop events and checks the device address byte. It then services writes of one byte or of a small page, and reads from the current address, from a chosen address, or as a run of consecutive bytes. It never drives the data line high. It only asserts a pull-low request, which the pad logic turns into an open-drain driver.

Received write data collects in a small page buffer. It goes into the storage array only when the master ends the transfer with a stop. A timed write cycle follows. While it runs, the slave refuses to acknowledge its own address, so a master can poll for completion. An internal address pointer keeps its value between transactions.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start; a rising data line while the clock is high is a stop. Either one, at any point, drops the transfer in progress, releases the data line, and (for a start) begins a new address byte. After reset the data line is released.
- R2: The address byte is sent MSB first; bits 7:4 must be 1010, bits 3:1 must be 000, and bit 0 selects read (1) or write (0). On a match the slave pulls the data line low during the ninth clock.
- R3: On an address mismatch no acknowledge is given, and every further byte up to the next start is also left unacknowledged.
- R4: In write mode the byte after the address is the word address, and it is acknowledged. Every data byte after it is also acknowledged.
- R5: A single data byte written and closed by a stop is stored at the word address.
- R6: Within a write, the low PAGE_W address bits (2 by default, a 4-byte page) step by one after each data byte and wrap inside the page while the upper bits stay fixed, so a fifth byte overwrites the first.
- R7: A stop that follows at least one data byte starts a write cycle of WCYCLE_CLKS system clocks. During it the address is never acknowledged, and after it acknowledges resume.
- R8: A stop with no data byte pending, such as after a word address alone, starts no write cycle.
- R9: A repeated start after data bytes discards them: nothing is stored and no write cycle begins.
- R10: The address pointer holds the last accessed location plus one and keeps it across transactions. A read with no word address returns data from the pointer.
- R11: A random read (word address, repeated start, read address) returns the byte at that word address, MSB first, with the data line changed only while the clock line is low.
- R12: During a read the pointer steps over all 8 bits after each byte, so a sequential read wraps from 255 to 0.
- R13: When the master does not acknowledge a read byte, the slave stops driving and stays released for any further clocks until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 requests the pad to pull the data line low |

## Verification
A protocol engine that slips one bit position shows up at the first acknowledge. The pull-low then lands on the eighth or tenth clock instead of the ninth, and the master sees a missing acknowledge. A pointer or page-index error stays hidden until a later read returns the wrong byte, so each write scenario is followed by a read-back. A stuck write-cycle state shows as an address that is never acknowledged, or one acknowledged too early. The poll that comes right after the stop exposes this within one address byte.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam logic [2:0] DEV_RSV  = 3'b000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WORD,
      ST_WDATA,
      ST_RDATA
   } twi_st_e;

   typedef enum logic [1:0] {
      WC_IDLE,
      WC_PROG,
      WC_WAIT
   } wc_phase_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_store_array.sv
module twi_store_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/twi_wr_cycle.sv
module twi_wr_cycle
   import twi_mem_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 2,
   parameter int WCYCLE_CLKS = 1000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_en,
   input  logic [PAGE_W-1:0]        ld_idx,
   input  logic [7:0]               ld_data,
   input  logic [ADDR_W-PAGE_W-1:0] ld_page,
   input  logic                     commit,
   input  logic                     discard,
   output logic                     busy,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_waddr,
   output logic [7:0]               mem_wdata
);
   localparam int SLOTS = 1 << PAGE_W;
   localparam int CW    = $clog2(WCYCLE_CLKS + 1);

   wc_phase_e                phase_q;
   logic [7:0]               slot_q [SLOTS];
   logic [SLOTS-1:0]         valid_q;
   logic [ADDR_W-PAGE_W-1:0] page_q;
   logic [PAGE_W-1:0]        idx_q;
   logic [CW-1:0]            cnt_q;

   always_ff @(posedge clk) begin
      if (ld_en && phase_q == WC_IDLE) slot_q[ld_idx] <= ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= WC_IDLE;
         valid_q <= '0;
         page_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            WC_IDLE: begin
               if (ld_en) begin
                  valid_q[ld_idx] <= 1'b1;
                  page_q          <= ld_page;
               end
               if (discard) valid_q <= '0;
               if (commit) begin
                  phase_q <= WC_PROG;
                  idx_q   <= '0;
               end
            end
            WC_PROG: begin
               idx_q <= idx_q + PAGE_W'(1);
               if (idx_q == PAGE_W'(SLOTS - 1)) begin
                  phase_q <= WC_WAIT;
                  cnt_q   <= '0;
               end
            end
            WC_WAIT: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(WCYCLE_CLKS - 1)) begin
                  phase_q <= WC_IDLE;
                  valid_q <= '0;
               end
            end
            default: phase_q <= WC_IDLE;
         endcase
      end
   end

   assign busy      = (phase_q != WC_IDLE);
   assign mem_we    = (phase_q == WC_PROG) && valid_q[idx_q];
   assign mem_waddr = {page_q, idx_q};
   assign mem_wdata = slot_q[idx_q];

   // R7: the engine commits only while no cycle is running
   a_r7_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !busy);
   // R9: a discard never meets a running cycle
   a_r9_discard_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      discard |-> !busy);
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
   import twi_mem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_s,
   input  logic                     sda_s,
   input  logic                     scl_rise,
   input  logic                     scl_fall,
   input  logic                     start_det,
   input  logic                     stop_det,
   input  logic                     wc_busy,
   input  logic [7:0]               rd_data,
   output logic                     sda_pull,
   output logic [ADDR_W-1:0]        cur_addr,
   output logic                     ld_en,
   output logic [PAGE_W-1:0]        ld_idx,
   output logic [7:0]               ld_data,
   output logic [ADDR_W-PAGE_W-1:0] ld_page,
   output logic                     commit,
   output logic                     discard
);
   twi_st_e     st_q, nxt_q;
   logic [3:0]  bitcnt_q;
   logic        in_ack_q;
   logic [7:0]  shreg_q;
   logic [7:0]  tx_q;
   logic        mack_q;
   logic        pending_q;
   logic        dev_match;
   logic [PAGE_W-1:0] lo_next;

   assign dev_match = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == DEV_RSV) && !wc_busy;
   assign lo_next   = cur_addr[PAGE_W-1:0] + PAGE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         nxt_q     <= ST_IDLE;
         bitcnt_q  <= '0;
         in_ack_q  <= 1'b0;
         shreg_q   <= '0;
         tx_q      <= '0;
         mack_q    <= 1'b0;
         pending_q <= 1'b0;
         sda_pull  <= 1'b0;
         cur_addr  <= '0;
         ld_en     <= 1'b0;
         ld_idx    <= '0;
         ld_data   <= '0;
         ld_page   <= '0;
         commit    <= 1'b0;
         discard   <= 1'b0;
      end else begin
         ld_en   <= 1'b0;
         commit  <= 1'b0;
         discard <= 1'b0;
         if (start_det) begin
            st_q     <= ST_DEV;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            sda_pull <= 1'b0;
            if (pending_q) begin
               discard   <= 1'b1;
               pending_q <= 1'b0;
            end
         end else if (stop_det) begin
            st_q     <= ST_IDLE;
            in_ack_q <= 1'b0;
            sda_pull <= 1'b0;
            if (pending_q) begin
               commit    <= 1'b1;
               pending_q <= 1'b0;
            end
         end else begin
            case (st_q)
               ST_DEV, ST_WORD, ST_WDATA: begin
                  if (scl_rise && !in_ack_q && bitcnt_q < 4'd8) begin
                     shreg_q  <= {shreg_q[6:0], sda_s};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
                  if (scl_fall) begin
                     if (in_ack_q) begin
                        in_ack_q <= 1'b0;
                        bitcnt_q <= '0;
                        st_q     <= nxt_q;
                        if (nxt_q == ST_RDATA) begin
                           tx_q     <= rd_data;
                           sda_pull <= ~rd_data[7];
                        end else begin
                           sda_pull <= 1'b0;
                        end
                     end else if (bitcnt_q == 4'd8) begin
                        case (st_q)
                           ST_DEV: begin
                              if (dev_match) begin
                                 sda_pull <= 1'b1;
                                 in_ack_q <= 1'b1;
                                 nxt_q    <= shreg_q[0] ? ST_RDATA : ST_WORD;
                              end else begin
                                 st_q <= ST_IDLE;
                              end
                           end
                           ST_WORD: begin
                              cur_addr <= shreg_q[ADDR_W-1:0];
                              sda_pull <= 1'b1;
                              in_ack_q <= 1'b1;
                              nxt_q    <= ST_WDATA;
                           end
                           default: begin
                              ld_en     <= 1'b1;
                              ld_idx    <= cur_addr[PAGE_W-1:0];
                              ld_page   <= cur_addr[ADDR_W-1:PAGE_W];
                              ld_data   <= shreg_q;
                              cur_addr  <= {cur_addr[ADDR_W-1:PAGE_W], lo_next};
                              pending_q <= 1'b1;
                              sda_pull  <= 1'b1;
                              in_ack_q  <= 1'b1;
                              nxt_q     <= ST_WDATA;
                           end
                        endcase
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     if (in_ack_q) mack_q <= ~sda_s;
                     else if (bitcnt_q < 4'd8) bitcnt_q <= bitcnt_q + 4'd1;
                  end
                  if (scl_fall) begin
                     if (in_ack_q) begin
                        in_ack_q <= 1'b0;
                        bitcnt_q <= '0;
                        if (mack_q) begin
                           tx_q     <= rd_data;
                           sda_pull <= ~rd_data[7];
                        end else begin
                           st_q     <= ST_IDLE;
                           sda_pull <= 1'b0;
                        end
                     end else if (bitcnt_q == 4'd8) begin
                        sda_pull <= 1'b0;
                        in_ack_q <= 1'b1;
                        mack_q   <= 1'b0;
                        cur_addr <= cur_addr + ADDR_W'(1);
                     end else if (bitcnt_q != 4'd0) begin
                        tx_q     <= {tx_q[6:0], 1'b0};
                        sda_pull <= ~tx_q[6];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R11: the pull request moves only while the synchronized clock line is low
   a_r11_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);
   // R7: no acknowledge of the address while a write cycle runs
   a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wc_busy && st_q == ST_DEV) |-> !sda_pull);
   // R1: a stop releases the line and parks the engine
   a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_pull && st_q == ST_IDLE));
   // R1: a start always begins address reception
   a_r1_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st_q == ST_DEV && !sda_pull));
   // R3: an idle engine never drives
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sda_pull);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 2,
   parameter int WCYCLE_CLKS = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_pull_o
);
   generate
      if (ADDR_W > 8 || ADDR_W <= PAGE_W) begin : g_bad_addr
         $error("twi_mem_slave: ADDR_W must be in PAGE_W+1..8");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("twi_mem_slave: PAGE_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twi_mem_slave: SYNC_STAGES must be at least 2");
      end
      if (WCYCLE_CLKS < 1) begin : g_bad_wc
         $error("twi_mem_slave: WCYCLE_CLKS must be positive");
      end
   endgenerate

   logic                     sda_s, scl_s, scl_rise, scl_fall, start_det, stop_det;
   logic                     wc_busy, mem_we;
   logic [ADDR_W-1:0]        cur_addr, mem_waddr;
   logic [7:0]               mem_wdata, rd_data, ld_data;
   logic                     ld_en, commit, discard;
   logic [PAGE_W-1:0]        ld_idx;
   logic [ADDR_W-PAGE_W-1:0] ld_page;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_proto_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .wc_busy(wc_busy), .rd_data(rd_data), .sda_pull(sda_pull_o),
      .cur_addr(cur_addr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .ld_page(ld_page), .commit(commit), .discard(discard)
   );

   twi_wr_cycle #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WCYCLE_CLKS(WCYCLE_CLKS)) u_wc (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .ld_page(ld_page), .commit(commit), .discard(discard), .busy(wc_busy),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   twi_store_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(cur_addr), .rdata(rd_data)
   );
endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
   localparam int WC = 1000;
   localparam int Q  = 10;
   localparam int H  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull;
   logic sda_line;

   int   n_chk = 0;
   int   n_bad = 0;
   int   viol  = 0;
   bit   done  = 1'b0;
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [8];

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   twi_mem_slave #(.WCYCLE_CLKS(WC)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull)
   );

   // R11: pull request must not change while the bus clock is high
   logic scl_prev = 1'b1, pull_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_prev && sda_pull !== pull_prev) viol <= viol + 1;
      scl_prev  <= scl_m;
      pull_prev <= sda_pull;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_m = 1'b1; hclk(Q);
      scl_m = 1'b1; hclk(H);
      sda_m = 1'b0; hclk(H);
      scl_m = 1'b0; hclk(Q);
   endtask

   task automatic bstop();
      sda_m = 1'b0; hclk(Q);
      scl_m = 1'b1; hclk(H);
      sda_m = 1'b1; hclk(H);
   endtask

   task automatic sbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hclk(Q);
         scl_m = 1'b1; hclk(H);
         scl_m = 1'b0; hclk(Q);
      end
      sda_m = 1'b1; hclk(Q);
      scl_m = 1'b1; hclk(H/2);
      ack = ~sda_line; hclk(H/2);
      scl_m = 1'b0; hclk(Q);
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         hclk(Q);
         scl_m = 1'b1; hclk(H/2);
         b = {b[6:0], sda_line}; hclk(H/2);
         scl_m = 1'b0; hclk(Q);
      end
      sda_m = ~mack; hclk(Q);
      scl_m = 1'b1; hclk(H);
      scl_m = 1'b0; hclk(Q);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input logic [7:0] a, input int n, input string req);
      logic k; logic all;
      bstart(); sbyte(8'hA0, k); all = k;
      sbyte(a, k); all &= k;
      for (int i = 0; i < n; i++) begin sbyte(wbuf[i], k); all &= k; end
      bstop();
      check(req, all, 1);
   endtask

   task automatic wait_ready(input string req);
      logic k; int tries;
      k = 1'b0; tries = 0;
      while (!k && tries < 40) begin
         bstart(); sbyte(8'hA0, k); bstop();
         tries++;
         if (!k) hclk(100);
      end
      check(req, k, 1);
   endtask

   task automatic rand_read(input logic [7:0] a, input int n, input string req);
      logic k; logic all;
      bstart(); sbyte(8'hA0, k); all = k;
      sbyte(a, k); all &= k;
      bstart(); sbyte(8'hA1, k); all &= k;
      for (int i = 0; i < n; i++) rbyte(i < n - 1, rbuf[i]);
      bstop();
      check(req, all, 1);
   endtask

   task automatic cur_read(input int n, input string req);
      logic k;
      bstart(); sbyte(8'hA1, k);
      check(req, k, 1);
      for (int i = 0; i < n; i++) rbyte(i < n - 1, rbuf[i]);
      bstop();
   endtask

   task automatic t_byte_write();
      logic k;
      wbuf[0] = 8'hA5;
      do_write(8'h10, 1, "R2 R4 address/word/data acks");
      bstart(); sbyte(8'hA0, k); bstop();
      check("R7 no ack during write cycle", k, 0);
      wait_ready("R7 ack returns after cycle");
      rand_read(8'h10, 1, "R11 random read acks");
      check("R5 R11 byte write readback", rbuf[0], 8'hA5);
   endtask

   task automatic t_page_write();
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      do_write(8'h20, 4, "R4 page acks");
      wait_ready("R7 page cycle end");
      rand_read(8'h20, 4, "R6 page read acks");
      check("R6 page byte0", rbuf[0], 8'h11);
      check("R6 page byte3", rbuf[3], 8'h44);
      for (int i = 0; i < 6; i++) wbuf[i] = 8'(i + 1);
      do_write(8'h32, 6, "R6 rollover acks");
      wait_ready("R7 rollover cycle end");
      rand_read(8'h30, 4, "R6 rollover read acks");
      check("R6 rollover 0x30", rbuf[0], 8'h03);
      check("R6 rollover 0x31", rbuf[1], 8'h04);
      check("R6 rollover 0x32", rbuf[2], 8'h05);
      check("R6 rollover 0x33", rbuf[3], 8'h06);
   endtask

   task automatic t_current();
      wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
      do_write(8'h40, 3, "R4 three-byte write");
      wait_ready("R7 cycle end");
      do_write(8'h40, 2, "R4 two-byte write");
      wait_ready("R7 cycle end");
      cur_read(1, "R10 current read ack");
      check("R10 pointer after write", rbuf[0], 8'h7C);
      rand_read(8'h20, 1, "R11 acks");
      cur_read(1, "R10 current read ack");
      check("R10 pointer after read", rbuf[0], 8'h22);
      cur_read(1, "R10 current read ack");
      check("R10 pointer persists", rbuf[0], 8'h33);
   endtask

   task automatic t_mismatch();
      logic k;
      bstart(); sbyte(8'hA2, k);
      check("R3 reserved bits nonzero", k, 0);
      sbyte(8'h00, k);
      check("R3 later byte ignored", k, 0);
      bstop();
      bstart(); sbyte(8'hB0, k); bstop();
      check("R3 wrong type", k, 0);
   endtask

   task automatic t_dummy_stop();
      logic k, all;
      bstart(); sbyte(8'hA0, k); all = k; sbyte(8'h10, k); all &= k; bstop();
      check("R4 dummy write acks", all, 1);
      bstart(); sbyte(8'hA0, k); bstop();
      check("R8 no write cycle after empty stop", k, 1);
      cur_read(1, "R10 ack");
      check("R10 pointer from word address", rbuf[0], 8'hA5);
   endtask

   task automatic t_abort();
      logic k, all;
      bstart(); sbyte(8'hA0, k); all = k; sbyte(8'h10, k); all &= k;
      sbyte(8'h3C, k); all &= k;
      bstart(); sbyte(8'hA0, k);
      check("R9 ack after restart (no cycle)", k, 1);
      sbyte(8'h10, k); all &= k;
      bstart(); sbyte(8'hA1, k); all &= k;
      rbyte(1'b0, rbuf[0]); bstop();
      check("R9 abort acks", all, 1);
      check("R9 discarded data not stored", rbuf[0], 8'hA5);
   endtask

   task automatic t_wrap();
      wbuf[0] = 8'hC0; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2; wbuf[3] = 8'hC3;
      do_write(8'hFC, 4, "R4 top page");
      wait_ready("R7 cycle end");
      wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; wbuf[2] = 8'hD2; wbuf[3] = 8'hD3;
      do_write(8'h00, 4, "R4 bottom page");
      wait_ready("R7 cycle end");
      rand_read(8'hFE, 4, "R12 acks");
      check("R12 addr 0xFE", rbuf[0], 8'hC2);
      check("R12 addr 0xFF", rbuf[1], 8'hC3);
      check("R12 wrap to 0x00", rbuf[2], 8'hD0);
      check("R12 addr 0x01", rbuf[3], 8'hD1);
   endtask

   task automatic t_nack_end();
      logic k; int pulls;
      bstart(); sbyte(8'hA0, k); sbyte(8'h20, k);
      bstart(); sbyte(8'hA1, k);
      rbyte(1'b0, rbuf[0]);
      pulls = 0;
      for (int i = 0; i < 9; i++) begin
         hclk(Q); scl_m = 1'b1; hclk(H/2);
         if (sda_pull) pulls++;
         hclk(H/2); scl_m = 1'b0; hclk(Q);
      end
      bstop();
      check("R13 read byte before nack", rbuf[0], 8'h11);
      check("R13 released after nack", pulls, 0);
   endtask

   initial begin
      hclk(5);
      check("R1 released in reset", sda_pull, 0);
      rst_n = 1'b1;
      hclk(10);
      check("R1 released after reset", sda_pull, 0);
      t_byte_write();
      t_page_write();
      t_current();
      t_mismatch();
      t_dummy_stop();
      t_abort();
      t_wrap();
      t_nack_end();
      check("R11 data changes only with clock low", viol, 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule